// File: doc/BRIEF.md
# CAN Controller Operating-Mode Manager

This block is the mode control unit of a CAN protocol controller. Software writes a control register that holds a self-clearing soft-reset bit and an enable bit. It also writes a mode-select register with loopback, sleep and snoop request bits. The block turns these bits into a single active operating mode: reset, configuration, loopback, sleep, snoop or normal. It reports that mode as an encoded output and as a read-only status vector.

While the controller sleeps, the block watches the bus receive line and the two transmit-buffer write strobes. Any activity on them clears the sleep request without software help. Entering sleep sets a sticky sleep interrupt flag. Leaving sleep for an active mode sets a sticky wake flag. Software clears each flag by writing 1 to it. The bit engine and the buffers sit around this block and follow the mode it reports.

Top module: `canmode_ctrl`

## Requirements
- R1: While `rst` is high, and for exactly one cycle after software writes 1 to control bit 0 (soft reset), `mode_o` is 0 (reset) and `status_o` is 5'b00001. A soft reset reads back as 0 in control bit 0 one cycle later. It returns enable (control bit 1), all mode-select bits and both interrupt flags to 0.
- R2: With enable 0 and no reset active, `mode_o` is 1 (configuration) and `status_o` is 5'b00001, whatever the mode-select bits hold.
- R3: With enable 1 and mode-select bit 0 (loopback) set, `mode_o` is 2 and `status_o` is 5'b00010, regardless of the sleep and snoop bits.
- R4: With enable 1, loopback 0 and mode-select bit 1 (sleep) set, `mode_o` is 3 and `status_o` is 5'b00100, regardless of the snoop bit.
- R5: With enable 1, loopback 0, sleep 0 and mode-select bit 2 (snoop) set, `mode_o` is 4 and `status_o` is 5'b11000 (normal and snoop both set).
- R6: With enable 1 and all mode-select bits clear, `mode_o` is 5 (normal) and `status_o` is 5'b01000.
- R7: Writes to the loopback and snoop bits take effect only while enable is 0. The sleep bit can be written in any mode.
- R8: The cycle after the mode becomes sleep, interrupt flag bit 0 (address 3) is set and `irq_o` is high.
- R9: In sleep mode only, a pulse on `txfifo_wr` or `txhp_wr` clears the sleep bit on the next edge. So does a falling edge of `rx_in` seen through a two-flop synchronizer, which gives the new mode at the third edge after `rx_in` falls. The cycle after the new mode appears, flag bit 1 is set. In other modes these inputs change nothing.
- R10: Software writing 0 to the sleep bit also ends sleep, and it sets flag bit 1 in the same way.
- R11: Interrupt flags stay set until a write to address 3 with 1 in their bit position. A write of 0 leaves them set. `irq_o` is the OR of the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address: 0 control, 1 mode-select, 2 status, 3 flags |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data at `bus_addr` |
| rx_in | input | 1 | Asynchronous CAN receive line, idle high |
| txfifo_wr | input | 1 | Transmit FIFO write strobe |
| txhp_wr | input | 1 | High-priority transmit buffer write strobe |
| mode_o | output | 3 | Active mode code (0 reset to 5 normal) |
| status_o | output | 5 | Bits: 0 config, 1 loopback, 2 sleep, 3 normal, 4 snoop |
| irq_o | output | 1 | OR of the sticky interrupt flags |

## Verification
The mode output and the status vector both come from the register state in the same cycle. A wrong priority or a missed write therefore shows on `mode_o` at the first negative edge after the write. A flag that is set late or cleared wrongly appears one cycle later on `irq_o` and in the flag register. A synchronizer of the wrong depth makes the exit from sleep come one edge early or late after `rx_in` falls. The bench samples both the edge before and the edge of the expected exit.

// File: rtl/canmode_pkg.sv
package canmode_pkg;

    typedef enum logic [2:0] {
        MODE_RESET    = 3'd0,
        MODE_CONFIG   = 3'd1,
        MODE_LOOPBACK = 3'd2,
        MODE_SLEEP    = 3'd3,
        MODE_SNOOP    = 3'd4,
        MODE_NORMAL   = 3'd5
    } op_mode_e;

    localparam int ADDR_CTRL = 0;
    localparam int ADDR_MSEL = 1;
    localparam int ADDR_STAT = 2;
    localparam int ADDR_IRQ  = 3;

    localparam int ST_W      = 5;
    localparam int ST_CONFIG = 0;
    localparam int ST_LOOP   = 1;
    localparam int ST_SLEEP  = 2;
    localparam int ST_NORMAL = 3;
    localparam int ST_SNOOP  = 4;

    typedef struct packed {
        logic snoop;
        logic sleep;
        logic loopback;
    } msel_t;

    typedef struct packed {
        logic wake;
        logic slp;
    } irq_t;

    // Fixed priority: reset, disabled, loopback, sleep, snoop, normal
    function automatic op_mode_e pick_mode(logic in_reset, logic enable, msel_t m);
        if (in_reset)        return MODE_RESET;
        else if (!enable)    return MODE_CONFIG;
        else if (m.loopback) return MODE_LOOPBACK;
        else if (m.sleep)    return MODE_SLEEP;
        else if (m.snoop)    return MODE_SNOOP;
        else                 return MODE_NORMAL;
    endfunction

    function automatic logic [ST_W-1:0] mode_status(op_mode_e m);
        logic [ST_W-1:0] s;
        s = '0;
        case (m)
            MODE_RESET, MODE_CONFIG: s[ST_CONFIG] = 1'b1;
            MODE_LOOPBACK:           s[ST_LOOP]   = 1'b1;
            MODE_SLEEP:              s[ST_SLEEP]  = 1'b1;
            MODE_SNOOP: begin
                s[ST_NORMAL] = 1'b1;
                s[ST_SNOOP]  = 1'b1;
            end
            default:                 s[ST_NORMAL] = 1'b1;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/canmode_decode.sv
module canmode_decode
    import canmode_pkg::*;
(
    input  logic            in_reset,
    input  logic            enable,
    input  msel_t           msel,
    output op_mode_e        mode,
    output logic [ST_W-1:0] status
);
    always_comb begin
        mode   = pick_mode(in_reset, enable, msel);
        status = mode_status(mode);
    end
endmodule

// File: rtl/canmode_wake.sv
module canmode_wake
    import canmode_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     rx_in,
    input  logic     tx_wr_a,
    input  logic     tx_wr_b,
    input  op_mode_e mode,
    output logic     hw_wake,
    output logic     enter_evt,
    output logic     wake_evt
);
    localparam int CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] rx_chain;
    op_mode_e           prev_mode;
    logic               rx_fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_chain  <= '1;
            prev_mode <= MODE_RESET;
        end else begin
            rx_chain  <= {rx_chain[CHAIN_W-2:0], rx_in};
            prev_mode <= mode;
        end
    end

    always_comb begin
        rx_fall   = rx_chain[CHAIN_W-1] & ~rx_chain[CHAIN_W-2];
        hw_wake   = (mode == MODE_SLEEP) && (rx_fall || tx_wr_a || tx_wr_b);
        enter_evt = (mode == MODE_SLEEP) && (prev_mode != MODE_SLEEP);
        wake_evt  = (prev_mode == MODE_SLEEP) &&
                    ((mode == MODE_NORMAL) || (mode == MODE_SNOOP));
    end
endmodule

// File: rtl/canmode_regs.sv
module canmode_regs
    import canmode_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              hw_wake,
    input  logic              enter_evt,
    input  logic              wake_evt,
    output logic              srst_q,
    output logic              en_q,
    output msel_t             msel_q,
    output irq_t              irq_q
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADDR_CTRL);
    localparam logic [ADDR_W-1:0] A_MSEL = ADDR_W'(ADDR_MSEL);
    localparam logic [ADDR_W-1:0] A_IRQ  = ADDR_W'(ADDR_IRQ);

    logic ctrl_wr, msel_wr, irq_wr, srst_req;

    always_comb begin
        ctrl_wr  = wr && (addr == A_CTRL);
        msel_wr  = wr && (addr == A_MSEL);
        irq_wr   = wr && (addr == A_IRQ);
        srst_req = ctrl_wr && wdata[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            srst_q <= 1'b0;
            en_q   <= 1'b0;
            msel_q <= '0;
            irq_q  <= '0;
        end else if (srst_q) begin
            srst_q <= 1'b0;
        end else if (srst_req) begin
            srst_q <= 1'b1;
            en_q   <= 1'b0;
            msel_q <= '0;
            irq_q  <= '0;
        end else begin
            if (ctrl_wr)
                en_q <= wdata[1];
            if (msel_wr) begin
                if (!en_q) begin
                    msel_q.loopback <= wdata[0];
                    msel_q.snoop    <= wdata[2];
                end
                msel_q.sleep <= wdata[1];
            end
            if (hw_wake)
                msel_q.sleep <= 1'b0;
            irq_q.slp  <= enter_evt | (irq_q.slp  & ~(irq_wr & wdata[0]));
            irq_q.wake <= wake_evt  | (irq_q.wake & ~(irq_wr & wdata[1]));
        end
    end
endmodule

// File: rtl/canmode_ctrl.sv
module canmode_ctrl
    import canmode_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              rx_in,
    input  logic              txfifo_wr,
    input  logic              txhp_wr,
    output logic [2:0]        mode_o,
    output logic [ST_W-1:0]   status_o,
    output logic              irq_o
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADDR_CTRL);
    localparam logic [ADDR_W-1:0] A_MSEL = ADDR_W'(ADDR_MSEL);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADDR_STAT);
    localparam logic [ADDR_W-1:0] A_IRQ  = ADDR_W'(ADDR_IRQ);

    logic     srst_q, en_q;
    msel_t    msel_q;
    irq_t     irq_q;
    op_mode_e mode_w;
    logic     hw_wake, enter_evt, wake_evt;

    canmode_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .hw_wake(hw_wake), .enter_evt(enter_evt), .wake_evt(wake_evt),
        .srst_q(srst_q), .en_q(en_q), .msel_q(msel_q), .irq_q(irq_q)
    );

    canmode_decode u_dec (
        .in_reset(rst | srst_q), .enable(en_q), .msel(msel_q),
        .mode(mode_w), .status(status_o)
    );

    canmode_wake #(.SYNC_STAGES(SYNC_STAGES)) u_wake (
        .clk(clk), .rst(rst), .rx_in(rx_in), .tx_wr_a(txfifo_wr),
        .tx_wr_b(txhp_wr), .mode(mode_w), .hw_wake(hw_wake),
        .enter_evt(enter_evt), .wake_evt(wake_evt)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL:  bus_rdata[1:0]      = {en_q, srst_q};
            A_MSEL:  bus_rdata[2:0]      = msel_q;
            A_STAT:  bus_rdata[ST_W-1:0] = status_o;
            A_IRQ:   bus_rdata[1:0]      = irq_q;
            default: bus_rdata           = '0;
        endcase
        mode_o = mode_w;
        irq_o  = |irq_q;
    end
endmodule

// File: rtl/canmode_checker.sv
module canmode_checker
    import canmode_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              txfifo_wr,
    input logic              txhp_wr,
    input op_mode_e          mode,
    input logic [ST_W-1:0]   status,
    input logic              srst_q,
    input logic              en_q,
    input msel_t             msel_q,
    input irq_t              irq_q
);
    logic srst_req, irq_clr0;
    always_comb begin
        srst_req = bus_wr && (bus_addr == ADDR_W'(ADDR_CTRL)) && bus_wdata[0];
        irq_clr0 = bus_wr && (bus_addr == ADDR_W'(ADDR_IRQ)) && bus_wdata[0];
    end

    a_r1_srst_pulse: assert property (@(posedge clk) disable iff (rst)
        srst_q |=> (!srst_q && !en_q && msel_q == '0));

    a_r1_reset_status: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_RESET) |-> (status == 5'b00001));

    a_r2_disabled_config: assert property (@(posedge clk) disable iff (rst)
        (!srst_q && !en_q) |-> (mode == MODE_CONFIG));

    a_r3_loop_wins: assert property (@(posedge clk) disable iff (rst)
        (en_q && !srst_q && msel_q.loopback) |-> (status == 5'b00010));

    a_r5_snoop_status: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_SNOOP) |-> (status == 5'b11000));

    a_r7_locked_bits: assert property (@(posedge clk) disable iff (rst)
        (en_q && !srst_q && !srst_req) |=>
            ($stable(msel_q.loopback) && $stable(msel_q.snoop)));

    a_r8_entry_flag: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_SLEEP && $past(mode) != MODE_SLEEP && !srst_req) |=> irq_q.slp);

    a_r9_tx_wake: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_SLEEP && (txfifo_wr || txhp_wr)) |=> !msel_q.sleep);

    a_r11_sticky: assert property (@(posedge clk) disable iff (rst)
        (irq_q.slp && !irq_clr0 && !srst_req && !srst_q) |=> irq_q.slp);
endmodule

bind canmode_ctrl canmode_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .txfifo_wr(txfifo_wr), .txhp_wr(txhp_wr),
    .mode(mode_w), .status(status_o), .srst_q(srst_q), .en_q(en_q),
    .msel_q(msel_q), .irq_q(irq_q)
);

// File: tb/canmode_ctrl_test.sv
module canmode_ctrl_test;
    localparam int DW = 8;
    localparam int AW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          rx_in = 1'b1;
    logic          txfifo_wr = 1'b0;
    logic          txhp_wr = 1'b0;
    logic [2:0]    mode_o;
    logic [4:0]    status_o;
    logic          irq_o;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    canmode_ctrl #(.DATA_W(DW), .ADDR_W(AW), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_in(rx_in),
        .txfifo_wr(txfifo_wr), .txhp_wr(txhp_wr), .mode_o(mode_o),
        .status_o(status_o), .irq_o(irq_o)
    );

    always #4 clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int a, input int d);
        bus_wr    = 1'b1;
        bus_addr  = AW'(a);
        bus_wdata = DW'(d);
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        bus_addr = AW'(a);
        #1;
        d = int'(bus_rdata);
    endtask

    task automatic pulse_fifo();
        txfifo_wr = 1'b1;
        @(negedge clk);
        txfifo_wr = 1'b0;
    endtask

    task automatic pulse_hp();
        txhp_wr = 1'b1;
        @(negedge clk);
        txhp_wr = 1'b0;
    endtask

    function automatic int exp_mode(input int en, input int m);
        if (en == 0)       return 1;
        if ((m & 1) != 0)  return 2;
        if ((m & 2) != 0)  return 3;
        if ((m & 4) != 0)  return 4;
        return 5;
    endfunction

    function automatic int exp_status(input int md);
        case (md)
            0, 1:    return 1;
            2:       return 2;
            3:       return 4;
            4:       return 24;
            default: return 8;
        endcase
    endfunction

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int v;
        tick(4);
        check("R1 mode in hw reset", int'(mode_o), 0);
        check("R1 status in hw reset", int'(status_o), 1);
        check("R1 irq in hw reset", int'(irq_o), 0);
        rst = 1'b0;
        tick(1);
        check("R2 config after reset", int'(mode_o), 1);

        // Exhaustive sweep of enable x mode-select
        for (int en = 0; en < 2; en++) begin
            for (int m = 0; m < 8; m++) begin
                int em;
                wr(0, 1);
                check("R1 soft reset mode", int'(mode_o), 0);
                check("R1 soft reset status", int'(status_o), 1);
                tick(1);
                rd(0, v);
                check("R1 srst self-clears", v, 0);
                wr(1, m);
                wr(0, en * 2);
                em = exp_mode(en, m);
                check("R2 R3 R4 R5 R6 mode", int'(mode_o), em);
                check("R2 R3 R4 R5 R6 status", int'(status_o), exp_status(em));
                rd(1, v);
                check("R7 msel readback", v, m);
                tick(1);
                check("R8 entry flag", int'(irq_o), (em == 3) ? 1 : 0);
            end
        end

        // R7: loopback/snoop locked while enabled, sleep writable
        wr(0, 1);
        tick(1);
        wr(0, 2);
        check("R6 normal", int'(mode_o), 5);
        wr(1, 5);
        rd(1, v);
        check("R7 lb/snoop ignored", v, 0);
        check("R7 mode stays normal", int'(mode_o), 5);
        wr(1, 7);
        rd(1, v);
        check("R7 only sleep taken", v, 2);
        check("R4 sleep from normal", int'(mode_o), 3);
        tick(1);
        rd(3, v);
        check("R8 sleep flag", v, 1);
        wr(3, 0);
        tick(2);
        rd(3, v);
        check("R11 write 0 keeps flag", v, 1);
        wr(3, 1);
        rd(3, v);
        check("R11 W1C clears", v, 0);
        check("R11 irq low", int'(irq_o), 0);

        // R9: transmit FIFO wake
        pulse_fifo();
        check("R9 fifo wake mode", int'(mode_o), 5);
        tick(1);
        rd(3, v);
        check("R9 wake flag fifo", v, 2);
        check("R11 irq high", int'(irq_o), 1);
        wr(3, 3);

        // R9: high-priority buffer wake
        wr(1, 2);
        tick(1);
        wr(3, 3);
        pulse_hp();
        check("R9 hp wake mode", int'(mode_o), 5);
        tick(1);
        rd(3, v);
        check("R9 wake flag hp", v, 2);
        wr(3, 3);

        // R9: receive edge wake through two-flop sync
        wr(1, 2);
        tick(1);
        wr(3, 3);
        rx_in = 1'b0;
        tick(1);
        check("R9 rx edge 1 still sleep", int'(mode_o), 3);
        tick(1);
        check("R9 rx edge 2 still sleep", int'(mode_o), 3);
        tick(1);
        check("R9 rx edge 3 wakes", int'(mode_o), 5);
        tick(1);
        rd(3, v);
        check("R9 wake flag rx", v, 2);
        rx_in = 1'b1;
        tick(4);
        wr(3, 3);

        // R9: receive edge outside sleep has no effect
        rx_in = 1'b0;
        tick(5);
        check("R9 rx in normal no mode change", int'(mode_o), 5);
        check("R9 rx in normal no flag", int'(irq_o), 0);
        rx_in = 1'b1;
        tick(4);

        // R10: software exit from sleep
        wr(1, 2);
        tick(1);
        wr(3, 3);
        wr(1, 0);
        check("R10 sw exit mode", int'(mode_o), 5);
        tick(1);
        rd(3, v);
        check("R10 wake flag", v, 2);

        // R9: strobe in loopback changes nothing
        wr(0, 1);
        tick(1);
        wr(1, 3);
        wr(0, 2);
        check("R3 loopback over sleep", int'(mode_o), 2);
        pulse_fifo();
        rd(1, v);
        check("R9 no wake in loopback", v, 3);
        check("R3 still loopback", int'(mode_o), 2);

        // R4/R5: sleep over snoop, wake into snoop
        wr(0, 1);
        tick(1);
        wr(1, 6);
        wr(0, 2);
        check("R4 sleep over snoop", int'(mode_o), 3);
        tick(1);
        wr(3, 3);
        pulse_hp();
        check("R5 wake into snoop", int'(mode_o), 4);
        check("R5 snoop status", int'(status_o), 24);
        tick(1);
        rd(3, v);
        check("R9 wake flag into snoop", v, 2);

        // R1: hardware reset mid-run
        rst = 1'b1;
        tick(1);
        check("R1 hw reset mode", int'(mode_o), 0);
        check("R1 hw reset status", int'(status_o), 1);
        check("R1 hw reset irq", int'(irq_o), 0);
        rst = 1'b0;
        tick(1);
        rd(1, v);
        check("R1 msel cleared", v, 0);
        check("R2 config after hw reset", int'(mode_o), 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule